// File: doc/BRIEF.md
# Multi-Channel 1D Convolution Engine

This block slides a short kernel along a row of packed pixels and produces one output value per position for each kernel in a small bank. Each 24-bit word carries three unsigned 8-bit channels, one in each byte lane. Every channel can be switched off by its own mask bit. Each output column is the sum of the per-channel products of the image window and the kernel. The block keeps these sums at 21-bit precision.

The image and the kernels sit in two local 32-word memories that the host fills through simple write ports. Results go to a 32-entry result memory that the host reads through an asynchronous read port. The host supplies the kernel length, the columns per kernel, the kernel count and the result count, each as its value minus one. It also supplies the channel mask, the kernel spacing mode and the pool enable.

A run is launched by a rising edge on `start`. The controller performs one tap per clock. An optional pooling stage keeps the larger of each pair of adjacent columns, comparing the full-precision sums before it truncates to 8 bits. `done` rises once the last result is in memory and stays high until `start` falls or `soft_rst` is pulsed.

The controller has five states:
- IDLE: waits for a rising edge on `start` (transition IDLE→TAP).
- TAP: accumulates one tap per cycle. It leaves for COL_END after the last tap.
- COL_END: hands the finished column sum to the pooling stage. It returns to TAP for the next column. After the last column of the last kernel it goes to FLUSH.
- FLUSH: lets the final result write land. It moves to DONE if `start` is still high and to IDLE otherwise.
- DONE: holds `done` until `start` falls (transition DONE→IDLE).

`soft_rst` forces any state to IDLE.

Top module: `conv1d_engine`

## Requirements
- R1: Output column c of kernel k is the sum, over taps t = 0 to `cfg_taps_m1`, of the products of image word (c+t) and kernel word (base_k+t), added channel by channel. The kernel has `cfg_taps_m1`+1 taps, each kernel yields `cfg_cols_m1`+1 columns, and there are `cfg_kern_m1`+1 kernels.
- R2: Channel n occupies bits [8n+7:8n] of a word. It contributes to the sum only when `cfg_ch_mask[n]` is 1.
- R3: The kernel base address is base_k = 4·k when `cfg_kstep_wide` is 0 and 8·k when it is 1.
- R4: With `cfg_pool_en` = 0, results are numbered k·(`cfg_cols_m1`+1)+c. Each result holds the low 8 bits of its column sum.
- R5: With `cfg_pool_en` = 1, columns c and c+1 (c even) of kernel k form a pair. The pair yields one result at the next sequential index: the larger of the two full 21-bit sums, with the second column taken on a tie, and then truncated to its low 8 bits.
- R6: Only result indices 0 to `cfg_res_cnt_m1` (and below 32) are written. All other entries of the result memory keep their contents.
- R7: A run starts only on a rising edge of `start` seen in IDLE. `done` rises only after the last result has been written, and no result is written while `done` is high.
- R8: `done` stays high while `start` stays high. It goes low in the cycle after `start` is seen low.
- R9: `soft_rst` returns the engine to IDLE, and `done` is low in the following cycle.
- R10: During and right after `rst_n` low, `done` is 0 and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to idle |
| start | input | 1 | Level run request; a rising edge launches a run |
| cfg_taps_m1 | input | 3 | Kernel length minus one |
| cfg_cols_m1 | input | 8 | Output columns per kernel minus one |
| cfg_kern_m1 | input | 3 | Kernel count minus one |
| cfg_res_cnt_m1 | input | 8 | Highest result index that may be written |
| cfg_ch_mask | input | 3 | Per-channel enable |
| cfg_kstep_wide | input | 1 | Kernel spacing: 0 = 4 words, 1 = 8 words |
| cfg_pool_en | input | 1 | Enable pairwise max pooling |
| img_we | input | 1 | Image memory write enable |
| img_waddr | input | 5 | Image memory write address |
| img_wdata | input | 24 | Image memory write data |
| ker_we | input | 1 | Kernel memory write enable |
| ker_waddr | input | 5 | Kernel memory write address |
| ker_wdata | input | 24 | Kernel memory write data |
| res_raddr | input | 5 | Result memory read address |
| res_rdata | output | 8 | Result memory read data (combinational) |
| done | output | 1 | Run complete |

## Verification
The bound checker watches the handshake on every cycle:
- `done` holds while `start` stays high (R8).
- `done` drops after `start` falls (R8) or after a soft reset (R9).
- The engine stays in IDLE without a request (R7), and no result is written while `done` is high (R7).
- Every result write lands at or below the configured result limit (R6).

The arithmetic can only be shown by the bench scenarios. These compare the memory contents against an independent model over different tap counts, channel masks, both kernel spacings, pooling on and off, and a case where pooling must compare above 8 bits. The bench also checks that entries above the result limit survive a later run.

// File: rtl/conv_pkg.sv
package conv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAP,
        ST_COL_END,
        ST_FLUSH,
        ST_DONE
    } eng_state_t;
endpackage

// File: rtl/conv_ram.sv
module conv_ram #(
    parameter int W  = 24,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/conv_mac.sv
module conv_mac #(
    parameter int CH_W  = 8,
    parameter int N_CH  = 3,
    parameter int SUM_W = 21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 first,
    input  logic [N_CH-1:0]      mask,
    input  logic [CH_W*N_CH-1:0] img_word,
    input  logic [CH_W*N_CH-1:0] ker_word,
    output logic [SUM_W-1:0]     acc
);
    localparam int PROD_W = 2 * CH_W;

    logic [PROD_W-1:0] ch_prod [N_CH];
    logic [SUM_W-1:0]  tap_sum;

    for (genvar g = 0; g < N_CH; g++) begin : g_lane
        assign ch_prod[g] = mask[g]
            ? img_word[g*CH_W +: CH_W] * ker_word[g*CH_W +: CH_W]
            : '0;
    end

    always_comb begin
        tap_sum = '0;
        for (int i = 0; i < N_CH; i++) begin
            tap_sum = tap_sum + SUM_W'(ch_prod[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (en) begin
            acc <= first ? tap_sum : acc + tap_sum;
        end
    end
endmodule

// File: rtl/conv_pool.sv
module conv_pool #(
    parameter int SUM_W  = 21,
    parameter int CH_W   = 8,
    parameter int IDX_W  = 11,
    parameter int LIM_W  = 8,
    parameter int AW     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pool_en,
    input  logic [LIM_W-1:0] res_lim,
    input  logic             sum_valid,
    input  logic             sum_first,
    input  logic [SUM_W-1:0] sum,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [CH_W-1:0]  wr_data
);
    localparam int DEPTH = 1 << AW;

    logic             half;
    logic [SUM_W-1:0] held;
    logic [IDX_W-1:0] out_idx;
    logic             emit;
    logic             take_held;
    logic             in_range;

    always_comb begin
        emit      = sum_valid && (!pool_en || (half && !sum_first));
        take_held = pool_en && (held > sum);
        in_range  = (out_idx <= IDX_W'(res_lim)) && (out_idx < IDX_W'(DEPTH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half    <= 1'b0;
            held    <= '0;
            out_idx <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else if (clr) begin
            half    <= 1'b0;
            out_idx <= '0;
            wr_en   <= 1'b0;
        end else begin
            wr_en   <= emit && in_range;
            wr_addr <= out_idx[AW-1:0];
            wr_data <= take_held ? held[CH_W-1:0] : sum[CH_W-1:0];
            if (emit) begin
                out_idx <= out_idx + 1'b1;
            end
            if (sum_valid && pool_en) begin
                if (sum_first || !half) begin
                    held <= sum;
                    half <= 1'b1;
                end else begin
                    half <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl
    import conv_pkg::*;
#(
    parameter int KLEN_W = 3,
    parameter int COLS_W = 8,
    parameter int KCNT_W = 3,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              start,
    input  logic [KLEN_W-1:0] taps_m1,
    input  logic [COLS_W-1:0] cols_m1,
    input  logic [KCNT_W-1:0] kern_m1,
    input  logic              kstep_wide,
    output logic [AW-1:0]     img_raddr,
    output logic [AW-1:0]     ker_raddr,
    output logic              mac_en,
    output logic              mac_first,
    output logic              sum_valid,
    output logic              sum_first,
    output logic              run_clr,
    output logic              done,
    output eng_state_t        state
);
    eng_state_t        state_nx;
    logic              start_q;
    logic              start_rise;
    logic [KLEN_W-1:0] tap;
    logic [COLS_W-1:0] col;
    logic [KCNT_W-1:0] kern;
    logic              last_tap;
    logic              last_col;
    logic              last_kern;
    logic [AW-1:0]     ker_base;

    assign start_rise = start && !start_q;
    assign last_tap   = (tap == taps_m1);
    assign last_col   = (col == cols_m1);
    assign last_kern  = (kern == kern_m1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start_rise) state_nx = ST_TAP;
            ST_TAP:     if (last_tap) state_nx = ST_COL_END;
            ST_COL_END: state_nx = (last_col && last_kern) ? ST_FLUSH : ST_TAP;
            ST_FLUSH:   state_nx = start ? ST_DONE : ST_IDLE;
            ST_DONE:    if (!start) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
        if (soft_rst) begin
            state_nx = ST_IDLE;
        end
    end

    // loop counters and start edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            tap     <= '0;
            col     <= '0;
            kern    <= '0;
        end else begin
            start_q <= start;
            unique case (state)
                ST_IDLE: begin
                    tap  <= '0;
                    col  <= '0;
                    kern <= '0;
                end
                ST_TAP: begin
                    if (!last_tap) begin
                        tap <= tap + 1'b1;
                    end
                end
                ST_COL_END: begin
                    tap <= '0;
                    if (last_col) begin
                        col  <= '0;
                        kern <= kern + 1'b1;
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                ST_FLUSH, ST_DONE: begin
                    tap <= '0;
                end
                default: begin
                    tap <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ker_base  = AW'(kern) << (kstep_wide ? 3 : 2);
        img_raddr = col[AW-1:0] + AW'(tap);
        ker_raddr = ker_base + AW'(tap);
        mac_en    = 1'b0;
        mac_first = 1'b0;
        sum_valid = 1'b0;
        sum_first = 1'b0;
        run_clr   = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                run_clr = start_rise && !soft_rst;
            end
            ST_TAP: begin
                mac_en    = 1'b1;
                mac_first = (tap == '0);
            end
            ST_COL_END: begin
                sum_valid = 1'b1;
                sum_first = (col == '0);
            end
            ST_FLUSH: begin
                done = 1'b0;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                done = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/conv1d_engine.sv
module conv1d_engine
    import conv_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int N_CH   = 3,
    parameter int AW     = 5,
    parameter int SUM_W  = 21,
    parameter int KLEN_W = 3,
    parameter int COLS_W = 8,
    parameter int KCNT_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 start,
    input  logic [KLEN_W-1:0]    cfg_taps_m1,
    input  logic [COLS_W-1:0]    cfg_cols_m1,
    input  logic [KCNT_W-1:0]    cfg_kern_m1,
    input  logic [COLS_W-1:0]    cfg_res_cnt_m1,
    input  logic [N_CH-1:0]      cfg_ch_mask,
    input  logic                 cfg_kstep_wide,
    input  logic                 cfg_pool_en,
    input  logic                 img_we,
    input  logic [AW-1:0]        img_waddr,
    input  logic [CH_W*N_CH-1:0] img_wdata,
    input  logic                 ker_we,
    input  logic [AW-1:0]        ker_waddr,
    input  logic [CH_W*N_CH-1:0] ker_wdata,
    input  logic [AW-1:0]        res_raddr,
    output logic [CH_W-1:0]      res_rdata,
    output logic                 done
);
    localparam int WORD_W = CH_W * N_CH;
    localparam int IDX_W  = COLS_W + KCNT_W;

    eng_state_t        state;
    logic [AW-1:0]     img_raddr;
    logic [AW-1:0]     ker_raddr;
    logic [WORD_W-1:0] img_word;
    logic [WORD_W-1:0] ker_word;
    logic              mac_en;
    logic              mac_first;
    logic              sum_valid;
    logic              sum_first;
    logic              run_clr;
    logic [SUM_W-1:0]  acc;
    logic              res_we;
    logic [AW-1:0]     res_waddr;
    logic [CH_W-1:0]   res_wdata;

    conv_ctrl #(
        .KLEN_W(KLEN_W), .COLS_W(COLS_W), .KCNT_W(KCNT_W), .AW(AW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .start      (start),
        .taps_m1    (cfg_taps_m1),
        .cols_m1    (cfg_cols_m1),
        .kern_m1    (cfg_kern_m1),
        .kstep_wide (cfg_kstep_wide),
        .img_raddr  (img_raddr),
        .ker_raddr  (ker_raddr),
        .mac_en     (mac_en),
        .mac_first  (mac_first),
        .sum_valid  (sum_valid),
        .sum_first  (sum_first),
        .run_clr    (run_clr),
        .done       (done),
        .state      (state)
    );

    conv_ram #(.W(WORD_W), .AW(AW)) u_img_ram (
        .clk   (clk),
        .we    (img_we),
        .waddr (img_waddr),
        .wdata (img_wdata),
        .raddr (img_raddr),
        .rdata (img_word)
    );

    conv_ram #(.W(WORD_W), .AW(AW)) u_ker_ram (
        .clk   (clk),
        .we    (ker_we),
        .waddr (ker_waddr),
        .wdata (ker_wdata),
        .raddr (ker_raddr),
        .rdata (ker_word)
    );

    conv_mac #(.CH_W(CH_W), .N_CH(N_CH), .SUM_W(SUM_W)) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mac_en),
        .first    (mac_first),
        .mask     (cfg_ch_mask),
        .img_word (img_word),
        .ker_word (ker_word),
        .acc      (acc)
    );

    conv_pool #(
        .SUM_W(SUM_W), .CH_W(CH_W), .IDX_W(IDX_W), .LIM_W(COLS_W), .AW(AW)
    ) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (run_clr),
        .pool_en   (cfg_pool_en),
        .res_lim   (cfg_res_cnt_m1),
        .sum_valid (sum_valid),
        .sum_first (sum_first),
        .sum       (acc),
        .wr_en     (res_we),
        .wr_addr   (res_waddr),
        .wr_data   (res_wdata)
    );

    conv_ram #(.W(CH_W), .AW(AW)) u_res_ram (
        .clk   (clk),
        .we    (res_we),
        .waddr (res_waddr),
        .wdata (res_wdata),
        .raddr (res_raddr),
        .rdata (res_rdata)
    );
endmodule

// File: rtl/conv1d_engine_chk.sv
module conv1d_engine_chk
    import conv_pkg::*;
#(
    parameter int AW     = 5,
    parameter int COLS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              start,
    input logic              done,
    input logic              res_we,
    input logic [AW-1:0]     res_waddr,
    input logic [COLS_W-1:0] cfg_res_cnt_m1,
    input eng_state_t        state
);
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start && !soft_rst) |=> done);  // R8

    AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);  // R8

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!done && state == ST_IDLE));  // R9

    AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> state == ST_IDLE);  // R7

    AST_NO_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !res_we);  // R7

    AST_WRITE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> (COLS_W'(res_waddr) <= cfg_res_cnt_m1));  // R6
endmodule

bind conv1d_engine conv1d_engine_chk #(.AW(AW), .COLS_W(COLS_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .soft_rst       (soft_rst),
    .start          (start),
    .done           (done),
    .res_we         (res_we),
    .res_waddr      (res_waddr),
    .cfg_res_cnt_m1 (cfg_res_cnt_m1),
    .state          (state)
);

// File: tb/sim_conv1d_engine.sv
`timescale 1ns/1ps
module sim_conv1d_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cfg_taps_m1 = '0;
    logic [7:0]  cfg_cols_m1 = '0;
    logic [2:0]  cfg_kern_m1 = '0;
    logic [7:0]  cfg_res_cnt_m1 = '0;
    logic [2:0]  cfg_ch_mask = '0;
    logic        cfg_kstep_wide = 1'b0;
    logic        cfg_pool_en = 1'b0;
    logic        img_we = 1'b0;
    logic [4:0]  img_waddr = '0;
    logic [23:0] img_wdata = '0;
    logic        ker_we = 1'b0;
    logic [4:0]  ker_waddr = '0;
    logic [23:0] ker_wdata = '0;
    logic [4:0]  res_raddr = '0;
    logic [7:0]  res_rdata;
    logic        done;

    always #2.5 clk = ~clk;

    conv1d_engine u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(start),
        .cfg_taps_m1(cfg_taps_m1), .cfg_cols_m1(cfg_cols_m1),
        .cfg_kern_m1(cfg_kern_m1), .cfg_res_cnt_m1(cfg_res_cnt_m1),
        .cfg_ch_mask(cfg_ch_mask), .cfg_kstep_wide(cfg_kstep_wide),
        .cfg_pool_en(cfg_pool_en),
        .img_we(img_we), .img_waddr(img_waddr), .img_wdata(img_wdata),
        .ker_we(ker_we), .ker_waddr(ker_waddr), .ker_wdata(ker_wdata),
        .res_raddr(res_raddr), .res_rdata(res_rdata), .done(done)
    );

    typedef struct {
        int         idx;
        logic [7:0] val;
        string      req;
    } item_t;

    item_t       sb_q[$];
    logic [23:0] img_m [32];
    logic [23:0] ker_m [32];
    logic [7:0]  res_m [32];
    bit          res_known [32];
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;
    event        ev_drain;
    bit          drained = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // monitor: pops expected items and compares against the result memory
    initial begin
        forever begin
            @(ev_drain);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                @(negedge clk);
                res_raddr = 5'(it.idx);
                #1;
                check(res_rdata === it.val, it.req, int'(res_rdata), int'(it.val));
            end
            drained = 1'b1;
        end
    end

    task automatic load_mems();
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            img_we = 1'b1; img_waddr = 5'(i); img_wdata = img_m[i];
            ker_we = 1'b1; ker_waddr = 5'(i); ker_wdata = ker_m[i];
        end
        @(negedge clk);
        img_we = 1'b0;
        ker_we = 1'b0;
    endtask

    function automatic int col_sum(int k, int c, int taps, bit wide, logic [2:0] mask);
        int s = 0;
        int base = k * (wide ? 8 : 4);
        for (int t = 0; t < taps; t++) begin
            for (int ch = 0; ch < 3; ch++) begin
                if (mask[ch]) begin
                    s += int'(img_m[(c + t) % 32][ch*8 +: 8]) *
                         int'(ker_m[(base + t) % 32][ch*8 +: 8]);
                end
            end
        end
        return s;
    endfunction

    // driver: computes expectations, pushes them, runs the engine
    task automatic run_case(input int taps, input int cols, input int kerns,
                            input int res_cnt, input logic [2:0] mask,
                            input bit wide, input bit pool, input string req,
                            input bit end_soft);
        int idx = 0;
        int waited = 0;
        for (int k = 0; k < kerns; k++) begin
            for (int c = 0; c < cols; c++) begin
                int v;
                int a;
                int b;
                bit emit = 1'b0;
                if (!pool) begin
                    v = col_sum(k, c, taps, wide, mask);
                    emit = 1'b1;
                end else if (c % 2 == 1) begin
                    a = col_sum(k, c - 1, taps, wide, mask);
                    b = col_sum(k, c, taps, wide, mask);
                    v = (a > b) ? a : b;
                    emit = 1'b1;
                end
                if (emit) begin
                    if (idx < res_cnt && idx < 32) begin
                        res_m[idx] = 8'(v);
                        res_known[idx] = 1'b1;
                    end
                    idx++;
                end
            end
        end
        for (int i = 0; i < 32; i++) begin
            if (res_known[i]) begin
                item_t it;
                it.idx = i;
                it.val = res_m[i];
                it.req = (i < res_cnt) ? req : "R6 untouched";
                sb_q.push_back(it);
            end
        end
        @(negedge clk);
        cfg_taps_m1    = 3'(taps - 1);
        cfg_cols_m1    = 8'(cols - 1);
        cfg_kern_m1    = 3'(kerns - 1);
        cfg_res_cnt_m1 = 8'(res_cnt - 1);
        cfg_ch_mask    = mask;
        cfg_kstep_wide = wide;
        cfg_pool_en    = pool;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R7 done low at run start", int'(done), 0);
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, "R7 done rises", int'(done), 1);
        drained = 1'b0;
        ->ev_drain;
        wait (drained);
        check(done == 1'b1, "R8 done holds with start high", int'(done), 1);
        if (end_soft) begin
            soft_rst = 1'b1;
            @(negedge clk);
            soft_rst = 1'b0;
            check(done == 1'b0, "R9 soft reset clears done", int'(done), 0);
            repeat (40) @(negedge clk);
            check(done == 1'b0, "R7 held start does not relaunch", int'(done), 0);
            start = 1'b0;
            @(negedge clk);
        end else begin
            start = 1'b0;
            @(negedge clk);
            check(done == 1'b0, "R8 done drops after start low", int'(done), 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            res_known[i] = 1'b0;
            res_m[i] = '0;
            img_m[i] = {8'(3 * i + 7), 8'(200 - i), 8'(9 * i)};
            ker_m[i] = {8'((i % 5) + 1), 8'((i % 3) + 2), 8'((i % 7) + 1)};
        end
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R10 done low in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R10 done low after reset", int'(done), 0);
        load_mems();

        // R5 pooling on, two taps, three kernels
        run_case(2, 8, 3, 12, 3'b111, 1'b0, 1'b1, "R5 pooled", 1'b0);
        // R1 / R4 pooling off, three taps
        run_case(3, 8, 3, 24, 3'b111, 1'b0, 1'b0, "R1 R4 plain", 1'b0);
        // R2 / R3 channel mask and wide kernel spacing
        run_case(4, 4, 3, 12, 3'b101, 1'b1, 1'b0, "R2 R3 mask wide", 1'b0);

        // R5 full-precision compare: pair sums 256 and 254
        for (int i = 0; i < 32; i++) begin
            img_m[i][7:0] = (i % 2 == 0) ? 8'd128 : 8'd127;
            ker_m[i][7:0] = 8'd2;
        end
        for (int i = 0; i < 32; i++) res_known[i] = 1'b0;
        load_mems();
        run_case(1, 8, 2, 8, 3'b001, 1'b0, 1'b1, "R5 full precision", 1'b0);

        // R6 result limit of 3, entries 3..7 keep the previous zeros
        run_case(2, 8, 1, 3, 3'b111, 1'b0, 1'b0, "R6 limited", 1'b1);

        finish_run();
    end
endmodule